// File: doc/BRIEF.md
# Panel Power-Up and Window Sequencer

This block brings a small 176 by 220 TFT panel controller from cold power-up to a state where it accepts pixel data, and then sets up an address window before each burst of pixels. It pulses the panel's hardware reset line, waits for the controller to settle, and replays a fixed list of command and parameter bytes with timed pauses of a set number of milliseconds between groups. Each byte leaves on a valid/ready word port together with a data/command flag, so a 9-bit SPI shifter (flag plus byte) can sit directly behind it.

Once the list has been sent, `done` rises. A window request then sends the memory-access-control command, with rotation and colour-order bits built from the `rot` and `bgr` inputs, followed by the column range, the row range and the memory-write command. After the memory-write command has been accepted, the pixel stream can follow on a separate path.

The controller is one state machine. S_IDLE goes to S_RST_LOW on `start`. S_RST_LOW goes to S_RST_WAIT when the reset-pulse timer expires. S_RST_WAIT goes to S_INIT when the boot wait expires. In S_INIT, a word entry stays in S_INIT and steps on each accept, a wait entry goes to S_INIT_WAIT, and the end entry goes to S_READY. S_INIT_WAIT returns to S_INIT when the millisecond timer expires. S_READY goes to S_WIN on `win_req`. S_WIN returns to S_READY when its last word is accepted.

Top module: `panel_init_seq`

## Requirements
- R1: After reset, `lcd_rst_n` is 1, `busy` and `done` are 0 and `wd_valid` is 0.
- R2: On `start` in idle, `busy` rises and `lcd_rst_n` goes low for at least RST_LOW_CYC cycles. At least BOOT_MS (120) milliseconds of CLK_PER_MS cycles then pass between its release and the acceptance of the first word.
- R3: The init words are sent in this order, with dc=0 for commands and dc=1 for parameters: C1 {FF 83 40}, 11, CA {70 00 D9}, B0 {01 11}, C9 {90 49 10 28 28 10 00 06}, B5 {35 20 45}, B4 {33 25 4C}, 3A {05}, 29 (hex).
- R4: Waits of at least 150, 20, 10 and 10 ms (and at most 16 cycles more, apart from stalls) follow the 11 command, the last C9 parameter, the last B4 parameter and the 29 command. The last of these waits ends before `done` rises.
- R5: While `wd_valid` is 1 and `wd_ready` is 0, the word and its flag hold steady. A word is transferred only on a cycle where both are 1.
- R6: When the list ends, `done` is 1 and `busy` is 0. From then on, `start` has no effect: no reset pulse and no words.
- R7: A window request sends 13 words: 36 {M}, 2A {00 xs 00 xe}, 2B {00 ys 00 ye}, 2C.
- R8: The access-control byte M has MY at bit 7, MX at bit 6, MV at bit 5 and BGR at bit 3. Rotation code 0 (0°) gives 00, 1 (90°) gives A0, 2 (180°) gives C0 and 3 (270°) gives 60. `bgr`=1 adds 08.
- R9: `win_req` is ignored before `done` and while a window is in progress.
- R10: `rot`, `bgr` and the corners are captured when the request is taken. Changes to them during the window have no effect.
- R11: `busy` is 1 and `done` is 0 from the cycle after the request until the 2C command is accepted. In the next cycle, `busy` is 0 and `done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin power-up sequence (idle only) |
| rot | input | 2 | Rotation code: 0=0°, 1=90°, 2=180°, 3=270° |
| bgr | input | 1 | Blue-green-red colour order flag |
| xs | input | 8 | Window start column |
| ys | input | 8 | Window start row |
| xe | input | 8 | Window end column |
| ye | input | 8 | Window end row |
| win_req | input | 1 | Window setup request strobe |
| wd_ready | input | 1 | Downstream accepts the word |
| lcd_rst_n | output | 1 | Panel hardware reset, active low |
| wd_valid | output | 1 | Word available |
| wd_dc | output | 1 | 0 = command byte, 1 = parameter byte |
| wd_byte | output | 8 | Command or parameter byte |
| busy | output | 1 | Sequence or window in progress |
| done | output | 1 | Init complete, idle for windows |

## Verification
The bench builds the block with CLK_PER_MS = 20 and RST_LOW_CYC = 6. With these values the full 310 ms of power-up waits shrinks to about 6,200 cycles, so every timed gap can be measured against its lower and upper bound in one short run. The downstream ready follows a two-in-three pattern, which covers the hold behaviour during stalls across the whole init list and all window sequences.

// File: rtl/panel_seq_pkg.sv
package panel_seq_pkg;

    localparam int BYTE_W      = 8;
    localparam int INIT_IDX_W  = 6;
    localparam int WIN_WORDS   = 13;
    localparam int WIN_IDX_W   = $clog2(WIN_WORDS);

    typedef enum logic [1:0] {
        E_WORD,
        E_WAIT,
        E_END
    } ent_kind_t;

    typedef struct packed {
        ent_kind_t          kind;
        logic               dc;
        logic [BYTE_W-1:0]  val;
    } rom_ent_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RST_LOW,
        S_RST_WAIT,
        S_INIT,
        S_INIT_WAIT,
        S_READY,
        S_WIN
    } seq_state_t;

    // MY bit7, MX bit6, MV bit5, BGR bit3
    function automatic logic [BYTE_W-1:0] access_byte(input logic [1:0] rot,
                                                      input logic bgr);
        logic [BYTE_W-1:0] b;
        unique case (rot)
            2'd0: b = 8'h00;
            2'd1: b = 8'hA0;
            2'd2: b = 8'hC0;
            2'd3: b = 8'h60;
        endcase
        return b | {4'b0000, bgr, 3'b000};
    endfunction

endpackage

// File: rtl/tick_timer.sv
module tick_timer #(
    parameter int UNIT  = 1,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] count,
    output logic             running
);
    localparam int SUB_W = (UNIT > 1) ? $clog2(UNIT) : 1;
    localparam logic [SUB_W-1:0] SUB_TOP = SUB_W'(UNIT - 1);

    logic [CNT_W-1:0] left;
    logic [SUB_W-1:0] sub;

    // running stays high for count*UNIT cycles after load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            left    <= '0;
            sub     <= '0;
        end else if (load) begin
            left    <= count;
            sub     <= SUB_TOP;
            running <= (count != '0);
        end else if (running) begin
            if (sub == '0) begin
                if (left == CNT_W'(1)) begin
                    running <= 1'b0;
                end else begin
                    left <= left - 1'b1;
                    sub  <= SUB_TOP;
                end
            end else begin
                sub <= sub - 1'b1;
            end
        end
    end
endmodule

// File: rtl/init_rom.sv
module init_rom
    import panel_seq_pkg::*;
(
    input  logic [INIT_IDX_W-1:0] idx,
    output rom_ent_t              ent
);
    function automatic rom_ent_t cmd(input logic [BYTE_W-1:0] v);
        return '{kind: E_WORD, dc: 1'b0, val: v};
    endfunction
    function automatic rom_ent_t prm(input logic [BYTE_W-1:0] v);
        return '{kind: E_WORD, dc: 1'b1, val: v};
    endfunction
    function automatic rom_ent_t pause(input logic [BYTE_W-1:0] ms);
        return '{kind: E_WAIT, dc: 1'b0, val: ms};
    endfunction

    always_comb begin
        case (idx)
            6'd0:  ent = cmd(8'hC1);
            6'd1:  ent = prm(8'hFF);
            6'd2:  ent = prm(8'h83);
            6'd3:  ent = prm(8'h40);
            6'd4:  ent = cmd(8'h11);
            6'd5:  ent = pause(8'd150);
            6'd6:  ent = cmd(8'hCA);
            6'd7:  ent = prm(8'h70);
            6'd8:  ent = prm(8'h00);
            6'd9:  ent = prm(8'hD9);
            6'd10: ent = cmd(8'hB0);
            6'd11: ent = prm(8'h01);
            6'd12: ent = prm(8'h11);
            6'd13: ent = cmd(8'hC9);
            6'd14: ent = prm(8'h90);
            6'd15: ent = prm(8'h49);
            6'd16: ent = prm(8'h10);
            6'd17: ent = prm(8'h28);
            6'd18: ent = prm(8'h28);
            6'd19: ent = prm(8'h10);
            6'd20: ent = prm(8'h00);
            6'd21: ent = prm(8'h06);
            6'd22: ent = pause(8'd20);
            6'd23: ent = cmd(8'hB5);
            6'd24: ent = prm(8'h35);
            6'd25: ent = prm(8'h20);
            6'd26: ent = prm(8'h45);
            6'd27: ent = cmd(8'hB4);
            6'd28: ent = prm(8'h33);
            6'd29: ent = prm(8'h25);
            6'd30: ent = prm(8'h4C);
            6'd31: ent = pause(8'd10);
            6'd32: ent = cmd(8'h3A);
            6'd33: ent = prm(8'h05);
            6'd34: ent = cmd(8'h29);
            6'd35: ent = pause(8'd10);
            default: ent = '{kind: E_END, dc: 1'b0, val: 8'h00};
        endcase
    end
endmodule

// File: rtl/panel_init_seq.sv
module panel_init_seq
    import panel_seq_pkg::*;
#(
    parameter int CLK_PER_MS  = 50000,
    parameter int RST_LOW_CYC = 500,
    parameter int BOOT_MS     = 120,
    parameter int MS_W        = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        rot,
    input  logic              bgr,
    input  logic [BYTE_W-1:0] xs,
    input  logic [BYTE_W-1:0] ys,
    input  logic [BYTE_W-1:0] xe,
    input  logic [BYTE_W-1:0] ye,
    input  logic              win_req,
    input  logic              wd_ready,
    output logic              lcd_rst_n,
    output logic              wd_valid,
    output logic              wd_dc,
    output logic [BYTE_W-1:0] wd_byte,
    output logic              busy,
    output logic              done
);
    localparam int RST_W = $clog2(RST_LOW_CYC + 1);
    localparam logic [WIN_IDX_W-1:0] WIN_LAST = WIN_IDX_W'(WIN_WORDS - 1);

    seq_state_t state, nxt;

    logic [INIT_IDX_W-1:0] idx;
    logic [WIN_IDX_W-1:0]  widx;
    rom_ent_t              ent;
    logic                  pin_q;
    logic [BYTE_W-1:0]     mad_q, xs_q, ys_q, xe_q, ye_q;
    logic                  rst_load, rst_run, ms_load, ms_run;
    logic [MS_W-1:0]       ms_cnt;
    logic                  acc;
    logic                  win_dc;
    logic [BYTE_W-1:0]     win_b;

    init_rom u_rom (.idx(idx), .ent(ent));

    tick_timer #(.UNIT(1), .CNT_W(RST_W)) u_rst_tmr (
        .clk(clk), .rst_n(rst_n), .load(rst_load),
        .count(RST_W'(RST_LOW_CYC)), .running(rst_run)
    );

    tick_timer #(.UNIT(CLK_PER_MS), .CNT_W(MS_W)) u_ms_tmr (
        .clk(clk), .rst_n(rst_n), .load(ms_load),
        .count(ms_cnt), .running(ms_run)
    );

    assign acc       = wd_valid && wd_ready;
    assign lcd_rst_n = pin_q;
    assign rst_load  = (state == S_IDLE) && start;
    assign ms_load   = ((state == S_RST_LOW) && !rst_run) ||
                       ((state == S_INIT) && (ent.kind == E_WAIT));
    assign ms_cnt    = (state == S_RST_LOW) ? MS_W'(BOOT_MS) : MS_W'(ent.val);

    // window word table
    always_comb begin
        win_dc = 1'b1;
        case (widx)
            4'd0:    begin win_dc = 1'b0; win_b = 8'h36; end
            4'd1:    win_b = mad_q;
            4'd2:    begin win_dc = 1'b0; win_b = 8'h2A; end
            4'd4:    win_b = xs_q;
            4'd6:    win_b = xe_q;
            4'd7:    begin win_dc = 1'b0; win_b = 8'h2B; end
            4'd9:    win_b = ys_q;
            4'd11:   win_b = ye_q;
            4'd12:   begin win_dc = 1'b0; win_b = 8'h2C; end
            default: win_b = 8'h00;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:      if (start) nxt = S_RST_LOW;
            S_RST_LOW:   if (!rst_run) nxt = S_RST_WAIT;
            S_RST_WAIT:  if (!ms_run) nxt = S_INIT;
            S_INIT: begin
                if (ent.kind == E_WAIT)     nxt = S_INIT_WAIT;
                else if (ent.kind == E_END) nxt = S_READY;
            end
            S_INIT_WAIT: if (!ms_run) nxt = S_INIT;
            S_READY:     if (win_req) nxt = S_WIN;
            S_WIN:       if (acc && (widx == WIN_LAST)) nxt = S_READY;
            default:     nxt = S_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx   <= '0;
            widx  <= '0;
            pin_q <= 1'b1;
            mad_q <= '0;
            xs_q  <= '0;
            ys_q  <= '0;
            xe_q  <= '0;
            ye_q  <= '0;
        end else begin
            if (state == S_IDLE) begin
                idx <= '0;
                if (start) pin_q <= 1'b0;
            end
            if ((state == S_RST_LOW) && !rst_run) pin_q <= 1'b1;
            if ((state == S_INIT) &&
                (((ent.kind == E_WORD) && acc) || (ent.kind == E_WAIT)))
                idx <= idx + 1'b1;
            if ((state == S_READY) && win_req) begin
                widx  <= '0;
                mad_q <= access_byte(rot, bgr);
                xs_q  <= xs;
                ys_q  <= ys;
                xe_q  <= xe;
                ye_q  <= ye;
            end
            if ((state == S_WIN) && acc) widx <= widx + 1'b1;
        end
    end

    // outputs
    always_comb begin
        wd_valid = 1'b0;
        wd_dc    = 1'b0;
        wd_byte  = '0;
        busy     = 1'b0;
        done     = 1'b0;
        unique case (state)
            S_IDLE: ;
            S_RST_LOW, S_RST_WAIT, S_INIT_WAIT: busy = 1'b1;
            S_INIT: begin
                busy     = 1'b1;
                wd_valid = (ent.kind == E_WORD);
                wd_dc    = ent.dc;
                wd_byte  = ent.val;
            end
            S_READY: done = 1'b1;
            S_WIN: begin
                busy     = 1'b1;
                wd_valid = 1'b1;
                wd_dc    = win_dc;
                wd_byte  = win_b;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/panel_seq_chk.sv
module panel_seq_chk #(
    parameter int RST_LOW_CYC = 500
) (
    input logic       clk,
    input logic       rst_n,
    input logic       lcd_rst_n,
    input logic       wd_valid,
    input logic       wd_ready,
    input logic       wd_dc,
    input logic [7:0] wd_byte,
    input logic       busy,
    input logic       done
);
    int unsigned low_run;

    always_ff @(posedge clk) begin
        if (!rst_n)          low_run <= 0;
        else if (!lcd_rst_n) low_run <= low_run + 1;
        else                 low_run <= 0;
    end

    // R5
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_valid && !wd_ready) |=> (wd_valid && $stable(wd_byte) && $stable(wd_dc)));

    // R2
    rst_pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lcd_rst_n) |-> ($past(low_run) >= RST_LOW_CYC));

    // R2
    quiet_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lcd_rst_n |-> (!wd_valid && busy));

    // R11
    valid_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wd_valid |-> (busy && !done));

    // R6
    done_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (lcd_rst_n && !wd_valid));
endmodule

bind panel_init_seq panel_seq_chk #(.RST_LOW_CYC(RST_LOW_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .lcd_rst_n(lcd_rst_n), .wd_valid(wd_valid),
    .wd_ready(wd_ready), .wd_dc(wd_dc), .wd_byte(wd_byte),
    .busy(busy), .done(done)
);

// File: tb/panel_init_seq_test.sv
module panel_init_seq_test;
    localparam int CPM = 20;
    localparam int RLC = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [1:0] rot = 2'd0;
    logic       bgr = 1'b0;
    logic [7:0] xs = 8'd0, ys = 8'd0, xe = 8'd0, ye = 8'd0;
    logic       win_req = 1'b0;
    logic       wd_ready = 1'b0;
    logic       lcd_rst_n, wd_valid, wd_dc, busy, done;
    logic [7:0] wd_byte;

    panel_init_seq #(.CLK_PER_MS(CPM), .RST_LOW_CYC(RLC)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .rot(rot), .bgr(bgr),
        .xs(xs), .ys(ys), .xe(xe), .ye(ye), .win_req(win_req),
        .wd_ready(wd_ready), .lcd_rst_n(lcd_rst_n), .wd_valid(wd_valid),
        .wd_dc(wd_dc), .wd_byte(wd_byte), .busy(busy), .done(done)
    );

    always #10 clk = ~clk;

    typedef struct {
        logic       dc;
        logic [7:0] v;
        int         gap_ms;
        bit         last;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0, n_fail = 0;
    int   cyc = 0, last_evt = 0, acc_cnt = 0, pulses = 0, low_cnt = 0;
    bit   prev_pin = 1'b1, prev_stall = 1'b0, ended = 1'b0;
    logic [7:0] prev_b;
    logic       prev_dc;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    task automatic push(input logic dc, input logic [7:0] v, input int gap,
                        input bit last);
        exp_t e;
        e.dc = dc; e.v = v; e.gap_ms = gap; e.last = last;
        q.push_back(e);
    endtask

    // R3 / R4 expected init list
    task automatic push_init();
        push(0, 8'hC1, 120, 0); push(1, 8'hFF, 0, 0); push(1, 8'h83, 0, 0);
        push(1, 8'h40, 0, 0);   push(0, 8'h11, 0, 0);
        push(0, 8'hCA, 150, 0); push(1, 8'h70, 0, 0); push(1, 8'h00, 0, 0);
        push(1, 8'hD9, 0, 0);
        push(0, 8'hB0, 0, 0);   push(1, 8'h01, 0, 0); push(1, 8'h11, 0, 0);
        push(0, 8'hC9, 0, 0);   push(1, 8'h90, 0, 0); push(1, 8'h49, 0, 0);
        push(1, 8'h10, 0, 0);   push(1, 8'h28, 0, 0); push(1, 8'h28, 0, 0);
        push(1, 8'h10, 0, 0);   push(1, 8'h00, 0, 0); push(1, 8'h06, 0, 0);
        push(0, 8'hB5, 20, 0);  push(1, 8'h35, 0, 0); push(1, 8'h20, 0, 0);
        push(1, 8'h45, 0, 0);
        push(0, 8'hB4, 0, 0);   push(1, 8'h33, 0, 0); push(1, 8'h25, 0, 0);
        push(1, 8'h4C, 0, 0);
        push(0, 8'h3A, 10, 0);  push(1, 8'h05, 0, 0);
        push(0, 8'h29, 0, 0);
    endtask

    // R7 / R8 expected window list
    task automatic push_win(input logic [1:0] r, input logic b,
                            input logic [7:0] x0, input logic [7:0] y0,
                            input logic [7:0] x1, input logic [7:0] y1);
        logic [7:0] m;
        case (r)
            2'd0: m = 8'h00;
            2'd1: m = 8'hA0;
            2'd2: m = 8'hC0;
            default: m = 8'h60;
        endcase
        if (b) m = m | 8'h08;
        push(0, 8'h36, 0, 0); push(1, m, 0, 0);
        push(0, 8'h2A, 0, 0); push(1, 8'h00, 0, 0); push(1, x0, 0, 0);
        push(1, 8'h00, 0, 0); push(1, x1, 0, 0);
        push(0, 8'h2B, 0, 0); push(1, 8'h00, 0, 0); push(1, y0, 0, 0);
        push(1, 8'h00, 0, 0); push(1, y1, 0, 0);
        push(0, 8'h2C, 0, 1);
    endtask

    // cycle counter and ready pattern (2 of 3)
    initial forever begin
        @(posedge clk);
        cyc++;
        #2 wd_ready = ((cyc % 3) != 2);
    end

    // monitor / scoreboard
    initial forever begin
        @(negedge clk);
        if (rst_n) begin
            if (prev_stall)
                chk(wd_valid && wd_byte == prev_b && wd_dc == prev_dc, "R5",
                    "held word", {23'd0, wd_dc, wd_byte}, {23'd0, prev_dc, prev_b});
            prev_stall = wd_valid && !wd_ready;
            prev_b = wd_byte;
            prev_dc = wd_dc;
            if (!lcd_rst_n) low_cnt++;
            if (lcd_rst_n && !prev_pin) begin
                pulses++;
                chk(low_cnt >= RLC, "R2", "reset low cycles", low_cnt, RLC);
                last_evt = cyc;
                low_cnt = 0;
            end
            prev_pin = lcd_rst_n;
            if (wd_valid && wd_ready) begin
                acc_cnt++;
                if (q.size() == 0) begin
                    chk(0, "R9", "unexpected word", {23'd0, wd_dc, wd_byte}, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(wd_dc == e.dc && wd_byte == e.v, "R3/R7", "word",
                        {23'd0, wd_dc, wd_byte}, {23'd0, e.dc, e.v});
                    if (e.gap_ms > 0) begin
                        chk(cyc - last_evt >= e.gap_ms * CPM, "R4", "gap min",
                            cyc - last_evt, e.gap_ms * CPM);
                        chk(cyc - last_evt <= e.gap_ms * CPM + 16, "R4", "gap max",
                            cyc - last_evt, e.gap_ms * CPM + 16);
                    end
                    if (e.last)
                        chk(busy && !done, "R11", "busy at 2C", {30'd0, busy, done}, 2);
                end
                last_evt = cyc;
            end
        end
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "WD", "watchdog expired", cyc, 0);
        finish_run();
    end

    task automatic pulse_win();
        @(posedge clk); #2 win_req = 1'b1;
        @(posedge clk); #2 win_req = 1'b0;
    endtask

    task automatic wait_window_end();
        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        chk(done && !busy, "R11", "done after 2C", {30'd0, busy, done}, 1);
    endtask

    task automatic run_window(input logic [1:0] r, input logic b,
                              input logic [7:0] x0, input logic [7:0] y0,
                              input logic [7:0] x1, input logic [7:0] y1);
        rot = r; bgr = b; xs = x0; ys = y0; xe = x1; ye = y1;
        push_win(r, b, x0, y0, x1, y1);
        pulse_win();
        @(negedge clk);
        chk(busy && !done, "R11", "busy after request", {30'd0, busy, done}, 2);
        wait_window_end();
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(lcd_rst_n && !busy && !done && !wd_valid, "R1", "reset state",
            {28'd0, lcd_rst_n, busy, done, wd_valid}, 8);

        // R9: request before init
        pulse_win();
        repeat (10) @(negedge clk);
        chk(!busy && !wd_valid && acc_cnt == 0, "R9", "early request",
            {30'd0, busy, wd_valid}, 0);

        // R2 / R3 / R4
        push_init();
        @(posedge clk); #2 start = 1'b1;
        @(posedge clk); #2 start = 1'b0;
        @(negedge clk);
        chk(busy && !lcd_rst_n, "R2", "busy and pin low", {30'd0, busy, lcd_rst_n}, 2);
        while (!done) @(negedge clk);
        chk(cyc - last_evt >= 10 * CPM, "R4", "final wait", cyc - last_evt, 10 * CPM);
        chk(q.size() == 0, "R3", "init words left", q.size(), 0);
        chk(!busy, "R6", "busy at done", busy, 0);
        chk(pulses == 1, "R2", "reset pulses", pulses, 1);

        // R6: start after done
        @(posedge clk); #2 start = 1'b1;
        @(posedge clk); #2 start = 1'b0;
        repeat (20) @(negedge clk);
        chk(pulses == 1 && lcd_rst_n && done && acc_cnt == 32, "R6",
            "start ignored", acc_cnt, 32);

        // R7 / R8 / R11
        run_window(2'd0, 1'b0, 8'd0, 8'd0, 8'd175, 8'd219);
        run_window(2'd1, 1'b1, 8'd10, 8'd20, 8'd30, 8'd40);
        run_window(2'd2, 1'b0, 8'd1, 8'd2, 8'd3, 8'd4);
        run_window(2'd3, 1'b1, 8'd175, 8'd219, 8'd175, 8'd219);
        run_window(2'd2, 1'b1, 8'd50, 8'd60, 8'd70, 8'd80);

        // R10: inputs change during window
        rot = 2'd1; bgr = 1'b0; xs = 8'h11; ys = 8'h22; xe = 8'h33; ye = 8'h44;
        push_win(2'd1, 1'b0, 8'h11, 8'h22, 8'h33, 8'h44);
        pulse_win();
        #1 rot = 2'd3; bgr = 1'b1; xs = 8'h99; ys = 8'h98; xe = 8'h97; ye = 8'h96;
        // R9: second request while window busy
        pulse_win();
        wait_window_end();
        repeat (30) @(negedge clk);
        chk(!wd_valid && done && acc_cnt == 32 + 13 * 6, "R9",
            "request while busy", acc_cnt, 32 + 13 * 6);

        finish_run();
    end
endmodule